// File: doc/BRIEF.md
# Frame Synchronous Scrambler

This block scrambles the transmit byte stream of a synchronous optical framer. It runs at the single-rate or triple-rate line speed, and it sits after the stage that writes the regenerator overhead. Each valid byte is XORed with eight bits from a pseudo-random generator. The generator restarts from all ones at a fixed point in every frame, so a receiver running the same logic recovers the data. The leading overhead bytes of the first row pass through untouched, and the generator is frozen while they pass.

The generator length is chosen at run time: the short standard sequence (the default) or one of two longer sequences meant for radio links. A new length choice, and a new rate, only take hold at the next frame start. Scrambling can be switched off by a configuration bit or by a pin. Either one is enough, and the generator keeps running while scrambling is off. Because the transform is its own inverse, the same block also works as a descrambler.

Top module: `frame_scrambler`

## Requirements
- R1: Every byte accepted with `inValid` high leaves on `outData` with `outValid` high exactly one clock later, in order. `outValid` is low in every other cycle.
- R2: After reset and before the first frame start, every byte passes through unchanged.
- R3: A byte with `inValid` and `inSof` both high opens a frame. The first valid bytes of the frame, counting the start byte, pass unchanged: 3 bytes when `stm1Sel` is 0 and 9 bytes when it is 1.
- R4: The byte after those overhead bytes is XORed with the first eight generator bits taken from an all-ones state. The first bit generated goes to data bit 7 and the eighth to bit 0.
- R5: `polySel` encoding: 0 selects x^7+x^6+1, 1 selects x^11+x^9+1, 2 selects x^13+x^12+x^10+x^9+1, and 3 acts as 0. The generator is an n-bit shift register whose output bit is its top bit. The XOR of the tap bits (x^n and the middle terms) shifts in at bit 0. With code 0 and zero data, the first scrambled byte is 8'hFE. Every later payload byte continues the same sequence.
- R6: `polySel` and `stm1Sel` are sampled only on a frame-start byte. Changes during a frame have no effect until the next frame start.
- R7: A byte on which `cfgScrambleOff` or `pinScrambleOff` is 1 passes unchanged. The generator still advances on that byte, so later bytes get the same mask they would have had without the bypass.
- R8: Cycles with `inValid` low move neither the overhead count nor the generator.
- R9: A frame start at any point, inside the overhead or inside the payload, restarts the overhead count and leads to a fresh reseed.
- R10: During reset `outValid` and `outData` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input byte strobe |
| inSof | input | 1 | Marks the first byte of a frame |
| inData | input | 8 | Input byte |
| polySel | input | 2 | Generator length select |
| stm1Sel | input | 1 | 1: triple-rate overhead width |
| cfgScrambleOff | input | 1 | Configuration bypass bit |
| pinScrambleOff | input | 1 | Bypass select pin |
| outValid | output | 1 | Output byte strobe |
| outData | output | 8 | Output byte |

## Verification
Two things can land in the same cycle: a change of `polySel` or `stm1Sel`, and a frame-start byte. The bench drives both on the same byte, and it also changes the selects in the middle of a frame. The reference model latches the selects only at the start, so any early or late pickup shows up as a mismatch on the payload bytes that follow. A bypass window set across the reseed point, and a frame start that arrives inside the overhead or the payload, are judged the same way. In each case the scoreboard compares every payload byte against the model.

// File: rtl/fsc_pkg.sv
`timescale 1ns/1ps
package fsc_pkg;
  typedef enum logic [1:0] {
    POLY_P7  = 2'd0,
    POLY_P11 = 2'd1,
    POLY_P13 = 2'd2,
    POLY_ALT = 2'd3
  } polyE;

  typedef struct packed {
    logic load;     // reseed from all ones and scramble this byte
    logic advance;  // scramble-position byte: step the generator
    logic apply;    // XOR the mask into the byte
  } ctrlStbS;

  localparam int LFSR_W = 13;
endpackage

// File: rtl/fsc_ctrl.sv
`timescale 1ns/1ps
module fsc_ctrl
  import fsc_pkg::*;
#(
  parameter int OH_BASE = 3,
  parameter int OH_MULT = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      inSof,
  input  logic [1:0] polySel,
  input  logic      stm1Sel,
  input  logic      bypass,
  output ctrlStbS   ctrlStb,
  output polyE      polyCur
);
  localparam int OH_MAX = OH_BASE * OH_MULT;
  localparam int CNT_W  = $clog2(OH_MAX + 2);

  logic             seenFrame;
  logic [CNT_W-1:0] ohCnt;
  logic [CNT_W-1:0] ohLen;
  polyE             polyReg;
  logic             stm1Reg;
  logic             isStart;
  logic             payload;
  logic             firstPay;

  always_comb begin
    ohLen    = stm1Reg ? CNT_W'(OH_MAX) : CNT_W'(OH_BASE);
    isStart  = inValid && inSof;
    payload  = inValid && !inSof && seenFrame && (ohCnt >= ohLen);
    firstPay = payload && (ohCnt == ohLen);
    ctrlStb.load    = firstPay;
    ctrlStb.advance = payload && !firstPay;
    ctrlStb.apply   = payload && !bypass;
    polyCur = polyReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenFrame <= 1'b0;
      ohCnt     <= '0;
      polyReg   <= POLY_P7;
      stm1Reg   <= 1'b0;
    end else if (isStart) begin
      seenFrame <= 1'b1;
      ohCnt     <= CNT_W'(1);
      polyReg   <= polyE'(polySel);
      stm1Reg   <= stm1Sel;
    end else if (inValid && seenFrame && (ohCnt <= ohLen)) begin
      ohCnt <= ohCnt + CNT_W'(1);
    end
  end

  // R6: the latched selection only moves on a frame-start byte
  p_poly_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && inSof) |=> $stable(polyReg) && $stable(stm1Reg));

  // R4: a reseed happens once per frame, never on two bytes in a row
  p_single_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStb.load |=> !ctrlStb.load);

  // R8: idle cycles leave the frame position untouched
  p_gap_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(ohCnt) && $stable(seenFrame));
endmodule

// File: rtl/fsc_datapath.sv
`timescale 1ns/1ps
module fsc_datapath
  import fsc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [7:0] inData,
  input  ctrlStbS    ctrlStb,
  input  polyE       poly,
  output logic       outValid,
  output logic [7:0] outData
);
  logic [LFSR_W-1:0] lfsr;
  logic [LFSR_W-1:0] widthMask;
  logic [LFSR_W-1:0] tapMask;
  logic [3:0]        msbIdx;
  logic [LFSR_W-1:0] nextState;
  logic [7:0]        seqBits;

  always_comb begin
    case (poly)
      POLY_P11: begin
        widthMask = LFSR_W'((1 << 11) - 1);
        tapMask   = LFSR_W'((1 << 10) | (1 << 8));
        msbIdx    = 4'd10;
      end
      POLY_P13: begin
        widthMask = LFSR_W'((1 << 13) - 1);
        tapMask   = LFSR_W'((1 << 12) | (1 << 11) | (1 << 9) | (1 << 8));
        msbIdx    = 4'd12;
      end
      default: begin
        widthMask = LFSR_W'((1 << 7) - 1);
        tapMask   = LFSR_W'((1 << 6) | (1 << 5));
        msbIdx    = 4'd6;
      end
    endcase
  end

  // Eight generator steps per byte, first bit into data bit 7
  always_comb begin
    logic [LFSR_W-1:0] st;
    logic              fb;
    st = ctrlStb.load ? widthMask : lfsr;
    seqBits = '0;
    for (int i = 0; i < 8; i++) begin
      seqBits[7-i] = st[msbIdx];
      fb = ^(st & tapMask);
      st = ((st << 1) | LFSR_W'(fb)) & widthMask;
    end
    nextState = st;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      lfsr     <= '1;
    end else begin
      outValid <= inValid;
      if (inValid) outData <= ctrlStb.apply ? (inData ^ seqBits) : inData;
      if (ctrlStb.load || ctrlStb.advance) lfsr <= nextState;
    end
  end

  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R7: an unscrambled byte leaves exactly as it came in
  p_pass_through_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !ctrlStb.apply) |=> outData == $past(inData));
  // R5: the generator never steps from the all-zero lock-up state
  p_state_live_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStb.advance |-> (lfsr & widthMask) != '0);
  p_gap_state_r8: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(lfsr));
endmodule

// File: rtl/frame_scrambler.sv
`timescale 1ns/1ps
module frame_scrambler
  import fsc_pkg::*;
#(
  parameter int OH_BASE = 3,
  parameter int OH_MULT = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inSof,
  input  logic [7:0] inData,
  input  logic [1:0] polySel,
  input  logic       stm1Sel,
  input  logic       cfgScrambleOff,
  input  logic       pinScrambleOff,
  output logic       outValid,
  output logic [7:0] outData
);
  ctrlStbS ctrlStb;
  polyE    polyCur;
  logic    bypass;

  assign bypass = cfgScrambleOff | pinScrambleOff;

  fsc_ctrl #(.OH_BASE(OH_BASE), .OH_MULT(OH_MULT)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inSof   (inSof),
    .polySel (polySel),
    .stm1Sel (stm1Sel),
    .bypass  (bypass),
    .ctrlStb (ctrlStb),
    .polyCur (polyCur)
  );

  fsc_datapath i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inData   (inData),
    .ctrlStb  (ctrlStb),
    .poly     (polyCur),
    .outValid (outValid),
    .outData  (outData)
  );
endmodule

// File: tb/test_frame_scrambler.sv
`timescale 1ns/1ps
module test_frame_scrambler;
  logic       clk = 1'b0;
  logic       rstN;
  logic       inValid, inSof;
  logic [7:0] inData;
  logic [1:0] polySel;
  logic       stm1Sel, cfgScrambleOff, pinScrambleOff;
  logic       outValid;
  logic [7:0] outData;

  always #2 clk = ~clk;

  frame_scrambler i_frame_scrambler (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inData(inData),
    .polySel(polySel), .stm1Sel(stm1Sel), .cfgScrambleOff(cfgScrambleOff),
    .pinScrambleOff(pinScrambleOff), .outValid(outValid), .outData(outData)
  );

  int         checks = 0;
  int         errors = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];
  string      phase = "";

  // Reference model state
  logic        mSeen = 1'b0;
  int          mCnt = 0;
  logic [1:0]  mPoly = 2'd0;
  logic        mStm1 = 1'b0;
  logic [15:0] mLfsr = 16'hFFFF;

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, phase, act, exp);
    end
  endtask

  task automatic genByte(output logic [7:0] mask);
    int n;
    logic b, fb;
    n = (mPoly == 2'd1) ? 11 : (mPoly == 2'd2) ? 13 : 7;
    mask = '0;
    for (int i = 0; i < 8; i++) begin
      b = mLfsr[n-1];
      case (mPoly)
        2'd1:    fb = mLfsr[10] ^ mLfsr[8];
        2'd2:    fb = mLfsr[12] ^ mLfsr[11] ^ mLfsr[9] ^ mLfsr[8];
        default: fb = mLfsr[6] ^ mLfsr[5];
      endcase
      mask  = {mask[6:0], b};
      mLfsr = {mLfsr[14:0], fb} & 16'((32'd1 << n) - 1);
    end
  endtask

  task automatic modelByte(input logic [7:0] d, input logic sof, output logic [7:0] e, output string t);
    int ohLen;
    logic [7:0] mask;
    if (sof) begin
      mSeen = 1'b1; mCnt = 0; mPoly = polySel; mStm1 = stm1Sel;
    end
    ohLen = mStm1 ? 9 : 3;
    if (!mSeen) begin
      e = d; t = "R2";
    end else if (mCnt < ohLen) begin
      e = d; t = "R3"; mCnt++;
    end else begin
      if (mCnt == ohLen) begin
        mLfsr = 16'((32'd1 << ((mPoly == 2'd1) ? 11 : (mPoly == 2'd2) ? 13 : 7)) - 1);
        mCnt++;
        t = "R4";
      end else t = "R5";
      genByte(mask);
      if (cfgScrambleOff || pinScrambleOff) begin
        e = d; t = "R7";
      end else e = d ^ mask;
    end
  endtask

  task automatic sendByte(input logic [7:0] d, input logic sof);
    logic [7:0] e;
    string t;
    @(negedge clk);
    inValid = 1'b1; inSof = sof; inData = d;
    modelByte(d, sof, e, t);
    expQ.push_back(e);
    tagQ.push_back(t);
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      inValid = 1'b0; inSof = 1'b0;
    end
  endtask

  // Monitor: compare each produced byte with the scoreboard head
  always @(negedge clk) begin
    if (rstN === 1'b1 && outValid === 1'b1) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R1 unexpected byte", outData, 8'h00);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(outData === e, t, outData, e);
      end
    end
  end

  initial begin
    #800000;
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; inSof = 1'b0; inData = '0;
    polySel = 2'd0; stm1Sel = 1'b0; cfgScrambleOff = 1'b0; pinScrambleOff = 1'b0;
    repeat (3) @(negedge clk);
    chk(outValid === 1'b0, "R10 outValid", {7'd0, outValid}, 8'h00);
    chk(outData === 8'h00, "R10 outData", outData, 8'h00);
    rstN = 1'b1;

    phase = "R2 before frame";
    for (int i = 0; i < 4; i++) sendByte(8'(8'hA5 + i), 1'b0);
    idle(2);

    phase = "R4 R5 short poly zero data";
    polySel = 2'd0; stm1Sel = 1'b0;
    sendByte(8'h00, 1'b1);
    for (int i = 0; i < 30; i++) sendByte(8'h00, 1'b0);

    phase = "R8 gaps";
    for (int i = 0; i < 20; i++) begin
      sendByte(8'(i * 13), 1'b0);
      if (i % 3 == 0) idle(i % 4 + 1);
    end

    phase = "R6 select change mid frame";
    polySel = 2'd1; stm1Sel = 1'b1;
    sendByte(8'h11, 1'b1);
    for (int i = 0; i < 40; i++) begin
      if (i == 15) begin polySel = 2'd2; stm1Sel = 1'b0; end
      sendByte(8'(i * 7), 1'b0);
    end

    phase = "R7 bypass windows";
    polySel = 2'd2; stm1Sel = 1'b1;
    sendByte(8'h3C, 1'b1);
    for (int i = 0; i < 60; i++) begin
      cfgScrambleOff = (i >= 8 && i < 12);
      pinScrambleOff = (i >= 25 && i < 31);
      sendByte(8'(i * 29), 1'b0);
    end
    cfgScrambleOff = 1'b0; pinScrambleOff = 1'b0;

    phase = "R5 code 3";
    polySel = 2'd3; stm1Sel = 1'b0;
    sendByte(8'h00, 1'b1);
    for (int i = 0; i < 20; i++) sendByte(8'h00, 1'b0);

    phase = "R9 restart";
    polySel = 2'd0;
    sendByte(8'h01, 1'b1);
    sendByte(8'h02, 1'b0);
    polySel = 2'd1;
    sendByte(8'h03, 1'b1);
    for (int i = 0; i < 10; i++) sendByte(8'(i + 100), 1'b0);
    sendByte(8'h09, 1'b1);
    for (int i = 0; i < 10; i++) sendByte(8'(i * 3), 1'b0);

    idle(4);
    chk(expQ.size() == 0, "R1 all bytes delivered", 8'(expQ.size()), 8'h00);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule